// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Interrupt Detection

This block is a register-mapped general-purpose I/O controller built from one or more identical 32-pin banks placed back to back in a single address window. Each pin can drive a value, optionally as an open-drain output that only ever pulls low, or act as an input. Every input pin watches for its own interrupt condition: a low level, a high level, a falling edge, a rising edge, or either edge.

Detected conditions are latched into a per-bank status register, which software clears by writing ones. A per-bank mask register selects which latched bits may raise the interrupt. The pending bits of all banks are combined into one shared interrupt output, so a single interrupt line serves the whole controller. Incoming pin values pass through a two-flop synchronizer before they are detected or read back.

Top module: `gpio_irq_block`

## Requirements
- R1: The address is a word address. Its low 3 bits pick the register in a bank (0 open-drain enable, 1 data, 2 direction, 3 edge select, 4 any-edge, 5 mask, 6 level, 7 status) and the bits above pick the bank, so bank N begins at word 8*N (byte 32*N). Reads return the addressed register combinationally.
- R2: A direction bit of 0 makes the pin an output driving its data bit on `pin_out`; 1 makes it an input. Reading the data register returns the driven value for output pins and the synchronized pin value for input pins.
- R3: `pin_oe` is asserted only for output pins; when a pin's open-drain bit is 1 its `pin_oe` is asserted only while its data bit is 0.
- R4: With level=0 and any-edge=0, edge-select=0 detects falling edges and 1 detects rising edges; with level=0 and any-edge=1 both edges are detected whatever edge-select holds. A pin change becomes visible in status after the third rising clock edge.
- R5: With level=1, edge-select=0 detects a low level and 1 a high level; the status bit is set again on every cycle the level is active, so a clear has no lasting effect until the level goes inactive.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged; if a detection and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: Reset clears open-drain enable, data, edge-select, any-edge, level, mask and status, sets direction to all ones, and leaves `irq_out` and every `pin_oe` low.
- R8: Status bits latch whatever the mask holds; `irq_out` is high when any status bit ANDed with its mask bit is 1, so an event latched while masked raises `irq_out` as soon as it is unmasked.
- R9: Events in any bank drive the one shared `irq_out`.
- R10: A pin configured as an output never sets its status bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3+BANK_BITS | Word address: register index in low 3 bits, bank above |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 32*NUM_BANKS | Pin input values, bank 0 in the low 32 bits |
| pin_out | output | 32*NUM_BANKS | Driven pin values |
| pin_oe | output | 32*NUM_BANKS | Pin output enables |
| irq_out | output | 1 | Shared interrupt of all banks |

## Verification
The two functions that can meet in one cycle are a pin's detection and a software clear of its own status bit. The bench provokes it by changing a rising-edge pin and launching the write-one-to-clear so that its commit edge is the same edge at which the event registers (the third edge after the pin change); the status bit must read back as set. The same collision is what makes a held level re-set its bit after every clear, which the bench judges by reading status after clearing with the level still active and again after the level is removed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_ODRAIN = 3'd0,
    IDX_DATA   = 3'd1,
    IDX_DIR    = 3'd2,
    IDX_ESEL   = 3'd3,
    IDX_EANY   = 3'd4,
    IDX_MASK   = 3'd5,
    IDX_LEVEL  = 3'd6,
    IDX_STAT   = 3'd7
  } reg_idx_e;

  // Edge detection: any-edge overrides edge-select; esel=1 rising, 0 falling.
  function automatic logic [REG_W-1:0] edge_hits(
    input logic [REG_W-1:0] esel,
    input logic [REG_W-1:0] eany,
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] prv);
    logic [REG_W-1:0] rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    return (eany & (rise | fall)) | (~eany & esel & rise) | (~eany & ~esel & fall);
  endfunction

  // Level detection: active when the pin equals the edge-select polarity.
  function automatic logic [REG_W-1:0] level_hits(
    input logic [REG_W-1:0] esel,
    input logic [REG_W-1:0] cur);
    return ~(cur ^ esel);
  endfunction

  // Output enable: outputs only, open-drain pins only while driving 0.
  function automatic logic [REG_W-1:0] drive_enable(
    input logic [REG_W-1:0] dir,
    input logic [REG_W-1:0] odrain,
    input logic [REG_W-1:0] dout);
    return ~dir & (~odrain | ~dout);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync,
  output logic [W-1:0] d_prev
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign d_sync = sync_q;
  assign d_prev = prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [REG_W-1:0] pin_in,
  output logic [REG_W-1:0] pin_out,
  output logic [REG_W-1:0] pin_oe,
  output logic             irq_req
);
  logic [REG_W-1:0] odrain, dout, dir, esel, eany, msk, lvl, stat;
  logic [REG_W-1:0] cur, prv;
  logic [REG_W-1:0] edge_hit, lvl_hit, pin_evt, clr_bits;
  logic             stat_wr;

  gpio_sync #(.W(REG_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .d_sync  (cur),
    .d_prev  (prv)
  );

  assign edge_hit = edge_hits(esel, eany, cur, prv);
  assign lvl_hit  = dir & lvl & level_hits(esel, cur);
  assign pin_evt  = dir & ((lvl & lvl_hit) | (~lvl & edge_hit));
  assign stat_wr  = wr_en && (reg_idx_e'(idx) == IDX_STAT);
  assign clr_bits = stat_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odrain <= '0;
      dout   <= '0;
      dir    <= '1;
      esel   <= '0;
      eany   <= '0;
      msk    <= '0;
      lvl    <= '0;
    end else if (wr_en) begin
      case (reg_idx_e'(idx))
        IDX_ODRAIN: odrain <= wdata;
        IDX_DATA:   dout   <= wdata;
        IDX_DIR:    dir    <= wdata;
        IDX_ESEL:   esel   <= wdata;
        IDX_EANY:   eany   <= wdata;
        IDX_MASK:   msk    <= wdata;
        IDX_LEVEL:  lvl    <= wdata;
        default:    ;
      endcase
    end
  end

  // Detection wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_bits) | pin_evt;
  end

  always_comb begin
    case (reg_idx_e'(idx))
      IDX_ODRAIN: rdata = odrain;
      IDX_DATA:   rdata = (dir & cur) | (~dir & dout);
      IDX_DIR:    rdata = dir;
      IDX_ESEL:   rdata = esel;
      IDX_EANY:   rdata = eany;
      IDX_MASK:   rdata = msk;
      IDX_LEVEL:  rdata = lvl;
      default:    rdata = stat;
    endcase
  end

  assign pin_out = dout;
  assign pin_oe  = drive_enable(dir, odrain, dout);
  assign irq_req = |(stat & msk);

  assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat & $past(wdata) & ~$past(pin_evt)) == '0));

  assert_set_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(pin_evt)) == '0));

  assert_level_reasserts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(lvl_hit)) == $past(lvl_hit)));

  assert_outputs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(dir)) == '0));

  assert_oe_outputs_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir) == '0);
endmodule

// File: rtl/gpio_irq_block.sv
module gpio_irq_block
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = IDX_W + BANK_BITS,
  localparam int PINS      = REG_W * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq_out
);
  logic [BANK_BITS-1:0] bank_sel;
  logic [IDX_W-1:0]     reg_idx;
  logic [REG_W-1:0]     bank_rdata [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  assign bank_sel = reg_addr[ADDR_W-1:IDX_W];
  assign reg_idx  = reg_addr[IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && (int'(bank_sel) == b)),
      .idx     (reg_idx),
      .wdata   (reg_wdata),
      .rdata   (bank_rdata[b]),
      .pin_in  (pin_in[b*REG_W +: REG_W]),
      .pin_out (pin_out[b*REG_W +: REG_W]),
      .pin_oe  (pin_oe[b*REG_W +: REG_W]),
      .irq_req (bank_irq[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (int'(bank_sel) == b) reg_rdata = bank_rdata[b];
  end

  assign irq_out = |bank_irq;
endmodule

// File: tb/gpio_irq_block_bench.sv
module gpio_irq_block_bench;
  localparam int NB = 2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_block #(.NUM_BANKS(NB)) u_gpio_irq_block (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

  // Row fields: {level, edge_sel, any_edge, v0, v1, expected status}
  localparam logic [5:0] TBL [12] = '{
    6'b000_10_1, 6'b000_01_0, 6'b010_01_1, 6'b010_10_0,
    6'b001_10_1, 6'b011_01_1, 6'b001_00_0, 6'b100_10_1,
    6'b100_01_0, 6'b110_01_1, 6'b110_10_0, 6'b011_11_0 };

  task automatic wr(input int bank, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(bank*8 + idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int bank, input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(bank*8 + idx);
    #1 d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [31:0] v;
    cycles(3);
    @(negedge clk) rst_n = 1'b1;
    // R7 reset values
    rd(0, 2, v); chk("R7 dir", v, 32'hFFFF_FFFF);
    rd(1, 5, v); chk("R7 mask", v, 0);
    rd(0, 7, v); chk("R7 status", v, 0);
    chk("R7 oe/irq", {pin_oe, 63'b0, irq_out}, 0);

    // R4 R5 table of interrupt types on bank 0 pin 3, mask 0
    foreach (TBL[i]) begin
      wr(0, 6, {28'b0, TBL[i][5], 3'b0});
      wr(0, 3, {28'b0, TBL[i][4], 3'b0});
      wr(0, 4, {28'b0, TBL[i][3], 3'b0});
      @(negedge clk) pin_in[3] = TBL[i][2];
      cycles(6);
      wr(0, 7, 32'hFFFF_FFFF);
      @(negedge clk) pin_in[3] = TBL[i][1];
      cycles(4);
      if (TBL[i][5]) begin
        wr(0, 7, 32'hFFFF_FFFF);
        cycles(1);
      end
      rd(0, 7, v);
      chk(TBL[i][5] ? "R5 level type" : "R4 edge type", v[3], TBL[i][0]);
      chk("R8 masked no irq", irq_out, 1'b0);
    end
    wr(0, 6, 0); wr(0, 3, 0); wr(0, 4, 0);
    @(negedge clk) pin_in[3] = 1'b0;
    cycles(5);
    wr(0, 7, 32'hFFFF_FFFF);

    // R5 level held active: clear has no lasting effect
    wr(0, 6, 32'h10); wr(0, 3, 32'h10);
    @(negedge clk) pin_in[4] = 1'b1;
    cycles(5);
    wr(0, 7, 32'h10);
    rd(0, 7, v); chk("R5 level re-set", v[4], 1'b1);
    @(negedge clk) pin_in[4] = 1'b0;
    cycles(4);
    wr(0, 7, 32'h10);
    rd(0, 7, v); chk("R5 cleared after release", v[4], 1'b0);
    wr(0, 6, 0); wr(0, 3, 0);

    // R4 latency and R6 write-0 no effect: rising on pin 1
    wr(0, 3, 32'h2);
    @(negedge clk) pin_in[1] = 1'b1;
    cycles(2);
    rd(0, 7, v); chk("R4 not yet at edge 2", v[1], 1'b0);
    cycles(1);
    rd(0, 7, v); chk("R4 set after edge 3", v[1], 1'b1);
    wr(0, 7, 32'hFFFF_FFFD);
    rd(0, 7, v); chk("R6 write 0 keeps", v[1], 1'b1);
    wr(0, 7, 32'h2);
    rd(0, 7, v); chk("R6 write 1 clears", v[1], 1'b0);

    // R6 same-cycle detection and clear: event wins
    @(negedge clk) pin_in[1] = 1'b0;
    cycles(3);
    @(negedge clk) pin_in[1] = 1'b1;
    cycles(2);
    wr(0, 7, 32'h2);
    rd(0, 7, v); chk("R6 event beats clear", v[1], 1'b1);
    wr(0, 7, 32'h2);

    // R8 masked latch then unmask
    chk("R8 irq masked", irq_out, 1'b0);
    @(negedge clk) pin_in[1] = 1'b0;
    cycles(3);
    @(negedge clk) pin_in[1] = 1'b1;
    cycles(4);
    chk("R8 still masked", irq_out, 1'b0);
    wr(0, 5, 32'h2);
    chk("R8 irq on unmask", irq_out, 1'b1);
    wr(0, 7, 32'h2);
    chk("R8 irq drops on clear", irq_out, 1'b0);
    wr(0, 5, 0);

    // R9 bank 1 event on shared irq, R1 bank stride
    wr(1, 3, 32'h20); wr(1, 5, 32'h20);
    @(negedge clk) pin_in[37] = 1'b1;
    cycles(4);
    chk("R9 shared irq from bank 1", irq_out, 1'b1);
    rd(1, 7, v); chk("R1 bank 1 status", v, 32'h20);
    rd(0, 7, v); chk("R1 bank 0 untouched", v, 0);
    rd(1, 1, v); chk("R2 input data read", v[5], 1'b1);
    wr(1, 7, 32'h20); wr(1, 5, 0);

    // R2 R3 outputs and open drain on bank 0 pin 0
    wr(0, 1, 32'h1); wr(0, 2, 32'hFFFF_FFFE);
    chk("R2 drive", {pin_out[0], pin_oe[0]}, 2'b11);
    rd(0, 1, v); chk("R2 data read output", v[0], 1'b1);
    wr(0, 0, 32'h1);
    chk("R3 open drain high released", pin_oe[0], 1'b0);
    wr(0, 1, 32'h0);
    chk("R3 open drain low driven", {pin_out[0], pin_oe[0]}, 2'b01);

    // R10 output pin input toggles set nothing
    wr(0, 4, 32'h1);
    @(negedge clk) pin_in[0] = 1'b1;
    cycles(4);
    @(negedge clk) pin_in[0] = 1'b0;
    cycles(4);
    rd(0, 7, v); chk("R10 output pin no event", v[0], 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cycles(100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule